// File: doc/BRIEF.md
# Receive Chunk Footer Engine

This block is the client-side data path of a MAC-PHY serial data interface. Each time the host clocks a data chunk out over SPI, the block serves a fixed-size payload taken from a byte-wide receive frame FIFO. It then appends a 32-bit footer, which tells the host what the payload holds and how the device stands. The footer gives the following:
- whether the payload carries frame data;
- where a frame starts, on a 4-byte word boundary, and at which byte a frame ends;
- how many receive chunks remain and how many transmit credits are free, both capped at 31;
- the configuration sync state;
- an extended-status flag.

The SPI shift logic asks for one byte at a time. The block keeps its position inside the chunk, so the payload and then the footer bytes come out in order. Frames are packed across chunk boundaries. A frame may begin only at an aligned word. When zero-align mode is on, a frame may begin only at the first byte of a payload. If a chunk has already reported one frame end, the closing byte of a second frame is held back to the next chunk, because the footer has room for a single end offset.

The block also drives an active-low interrupt line. The line goes low when a resource is reported as newly available: receive chunks, transmit credits or extended status, each compared with what the last footer said. It goes high again when the first data header of the next transfer arrives.

Top module: `rce_engine`

## Requirements
- R1: A chunk is PAYLOAD_BYTES payload bytes followed by 4 footer bytes, most significant byte first. The position advances only on a cycle with `spi_byte_req` high, and the requested byte appears on `spi_byte_out` after that clock edge.
- R2: Footer layout: bit 31 extended status, bit 30 zero, bit 29 sync, bits 28:24 receive chunks, bits 23:22 zero, bit 21 data valid, bit 20 start valid, bits 19:16 start word offset, bit 15 zero, bit 14 end valid, bits 13:8 end byte offset, bits 7:6 zero, bits 5:1 transmit credits. Bit 0 makes the count of ones in the 32-bit word odd.
- R3: Data valid is 1 exactly when at least one frame byte sits in the payload. Unused payload bytes are zero, and a chunk without frame data reports data valid, start valid, end valid and both offsets as zero.
- R4: A frame starts only at a payload byte whose index is a multiple of 4, and at most once per chunk. Start valid is then 1 and the start word offset is that index divided by 4.
- R5: The last byte of a frame sets end valid and puts its payload index in the end byte offset. If end valid is already set in the chunk, that byte waits and is served at the next chunk.
- R6: With `zero_align` high, a frame starts only at payload byte 0. Bytes after a frame end in the same chunk stay zero.
- R7: The footer sync bit equals `cfg_sync`. While `cfg_sync` is low, no FIFO byte is popped and the payload is all zero.
- R8: The footer extended-status bit equals `exst_in`.
- R9: The receive-chunk and transmit-credit fields carry `rx_chunks_in` and `tx_credits_in`, limited to 31.
- R10: `irq_n` falls when receive chunks, transmit credits or extended status becomes available after the last footer reported none. It rises on the clock after `spi_hdr_seen`, which wins over a new event in the same cycle.
- R11: Footer fields are sampled at the edge that serves the last payload byte.
- R12: After reset `irq_n` is 1, `spi_byte_out` is 0 and the chunk position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sync | input | 1 | Configuration sync; enables data transfer |
| zero_align | input | 1 | Frames start only at payload byte 0 |
| exst_in | input | 1 | Extended status event pending |
| rx_chunks_in | input | CNT_W | Receive chunks available |
| tx_credits_in | input | CNT_W | Transmit credits available |
| rxf_valid | input | 1 | Receive FIFO has a byte |
| rxf_data | input | 8 | Receive FIFO head byte |
| rxf_sof | input | 1 | Head byte is the first of a frame |
| rxf_eof | input | 1 | Head byte is the last of a frame |
| rxf_pop | output | 1 | Consume the FIFO head at this edge |
| spi_byte_req | input | 1 | SPI logic requests the next chunk byte |
| spi_hdr_seen | input | 1 | First data header of a transfer received |
| spi_byte_out | output | 8 | Chunk byte for the shift register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the engine with PAYLOAD_BYTES = 16 and CNT_W = 8. The 20-byte chunk keeps every corner short: a frame ending on the last payload byte, frames spanning two chunks, a start at word offset 1, and a second frame end deferred into the next chunk. With 8-bit count inputs, the bench can drive values of 32 to 255, so the cap at 31 is exercised for both the receive-chunk and the transmit-credit field.

// File: rtl/rce_pkg.sv
package rce_pkg;

   localparam int FTR_BYTES  = 4;
   localparam int CNT_FLD_W  = 5;
   localparam int SWO_W      = 4;
   localparam int EBO_W      = 6;

   typedef struct packed {
      logic                 exst;
      logic                 sync;
      logic [CNT_FLD_W-1:0] rca;
      logic                 dv;
      logic                 sv;
      logic [SWO_W-1:0]     swo;
      logic                 ev;
      logic [EBO_W-1:0]     ebo;
      logic [CNT_FLD_W-1:0] txc;
   } footer_t;

   function automatic logic [31:0] pack_footer(footer_t f);
      logic [31:0] w;
      w = {f.exst, 1'b0, f.sync, f.rca, 2'b00, f.dv, f.sv, f.swo,
           1'b0, f.ev, f.ebo, 2'b00, f.txc, 1'b0};
      w[0] = ~^w[31:1];
      return w;
   endfunction

endpackage

// File: rtl/rce_payload.sv
module rce_payload #(
   parameter int PAYLOAD_BYTES = 64,
   localparam int PI_W = $clog2(PAYLOAD_BYTES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      step,
   input  logic                      last,
   input  logic [PI_W-1:0]           pidx,
   input  logic                      cfg_sync,
   input  logic                      zero_align,
   input  logic                      rxf_valid,
   input  logic [7:0]                rxf_data,
   input  logic                      rxf_sof,
   input  logic                      rxf_eof,
   output logic                      pop,
   output logic [7:0]                pl_byte,
   output logic                      dv_n,
   output logic                      sv_n,
   output logic [rce_pkg::SWO_W-1:0] swo_n,
   output logic                      ev_n,
   output logic [rce_pkg::EBO_W-1:0] ebo_n
);
   import rce_pkg::*;

   logic             in_frame_q, in_frame_n;
   logic             dv_q, sv_q, ev_q;
   logic [SWO_W-1:0] swo_q;
   logic [EBO_W-1:0] ebo_q;
   logic             start_ok;

   assign start_ok = (pidx[1:0] == 2'b00) && !sv_q &&
                     (!zero_align || pidx == '0) && !(rxf_eof && ev_q);

   always_comb begin
      in_frame_n = in_frame_q;
      dv_n  = dv_q;
      sv_n  = sv_q;
      swo_n = swo_q;
      ev_n  = ev_q;
      ebo_n = ebo_q;
      pop     = 1'b0;
      pl_byte = 8'h00;
      if (step && cfg_sync) begin
         if (in_frame_q) begin
            if (rxf_valid && !(rxf_eof && ev_q)) begin
               pop     = 1'b1;
               pl_byte = rxf_data;
               dv_n    = 1'b1;
               if (rxf_eof) begin
                  in_frame_n = 1'b0;
                  ev_n       = 1'b1;
                  ebo_n      = EBO_W'(pidx);
               end
            end
         end else if (rxf_valid && rxf_sof && start_ok) begin
            pop        = 1'b1;
            pl_byte    = rxf_data;
            dv_n       = 1'b1;
            sv_n       = 1'b1;
            swo_n      = SWO_W'(pidx >> 2);
            in_frame_n = !rxf_eof;
            if (rxf_eof) begin
               ev_n  = 1'b1;
               ebo_n = EBO_W'(pidx);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         dv_q  <= 1'b0;
         sv_q  <= 1'b0;
         swo_q <= '0;
         ev_q  <= 1'b0;
         ebo_q <= '0;
      end else if (step) begin
         in_frame_q <= in_frame_n;
         if (last) begin
            dv_q  <= 1'b0;
            sv_q  <= 1'b0;
            swo_q <= '0;
            ev_q  <= 1'b0;
            ebo_q <= '0;
         end else begin
            dv_q  <= dv_n;
            sv_q  <= sv_n;
            swo_q <= swo_n;
            ev_q  <= ev_n;
            ebo_q <= ebo_n;
         end
      end
   end

   AST_NO_POP_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_sync |-> !pop);                                          // R7
   AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> rxf_valid);                                           // R5
   AST_ZA_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && zero_align && !sv_q && sv_n) |-> pidx == '0);        // R6
   AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !sv_q && sv_n) |-> pidx[1:0] == 2'b00);              // R4
   AST_EMPTY_NO_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !dv_n) |-> (!sv_n && !ev_n));                        // R3

endmodule

// File: rtl/rce_footer.sv
module rce_footer #(
   parameter int CNT_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      latch,
   input  logic                      cfg_sync,
   input  logic                      exst_in,
   input  logic [CNT_W-1:0]          rx_chunks_in,
   input  logic [CNT_W-1:0]          tx_credits_in,
   input  logic                      dv,
   input  logic                      sv,
   input  logic [rce_pkg::SWO_W-1:0] swo,
   input  logic                      ev,
   input  logic [rce_pkg::EBO_W-1:0] ebo,
   output logic [31:0]               word
);
   import rce_pkg::*;

   localparam logic [CNT_FLD_W-1:0] FLD_MAX = '1;

   logic [CNT_FLD_W-1:0] rca_s, txc_s;
   footer_t              f_q;

   generate
      if (CNT_W > CNT_FLD_W) begin : g_sat
         assign rca_s = (rx_chunks_in  > CNT_W'(FLD_MAX)) ? FLD_MAX : rx_chunks_in[CNT_FLD_W-1:0];
         assign txc_s = (tx_credits_in > CNT_W'(FLD_MAX)) ? FLD_MAX : tx_credits_in[CNT_FLD_W-1:0];
      end else begin : g_pass
         assign rca_s = rx_chunks_in;
         assign txc_s = tx_credits_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q <= '0;
      end else if (latch) begin
         f_q <= '{exst: exst_in, sync: cfg_sync, rca: rca_s, dv: dv, sv: sv,
                  swo: swo, ev: ev, ebo: ebo, txc: txc_s};
      end
   end

   assign word = pack_footer(f_q);

   AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(word) % 2) == 1);                                 // R2
   AST_RCA_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && rx_chunks_in > CNT_W'(FLD_MAX)) |=> word[28:24] == FLD_MAX); // R9
   AST_TXC_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && tx_credits_in > CNT_W'(FLD_MAX)) |=> word[5:1] == FLD_MAX);  // R9
   AST_SYNC_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> word[29] == $past(cfg_sync));                       // R7

endmodule

// File: rtl/rce_irq.sv
module rce_irq #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             latch,
   input  logic [CNT_W-1:0] rx_chunks_in,
   input  logic [CNT_W-1:0] tx_credits_in,
   input  logic             exst_in,
   input  logic             spi_hdr_seen,
   output logic             irq_n
);
   localparam int NSRC = 3;

   logic [NSRC-1:0] none_q, avail, cond, cond_q;
   logic            irq_q;

   assign avail = {rx_chunks_in != '0, tx_credits_in != '0, exst_in};
   assign cond  = none_q & avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         none_q <= '1;
         cond_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (latch) none_q <= ~avail;
         cond_q <= cond;
         if (spi_hdr_seen)               irq_q <= 1'b0;
         else if (|(cond & ~cond_q))     irq_q <= 1'b1;
      end
   end

   assign irq_n = ~irq_q;

   AST_HDR_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      spi_hdr_seen |=> irq_n);                                      // R10
   AST_IRQ_NOT_ON_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(!spi_hdr_seen));                       // R10

endmodule

// File: rtl/rce_engine.sv
module rce_engine #(
   parameter int PAYLOAD_BYTES = 64,
   parameter int CNT_W         = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_sync,
   input  logic             zero_align,
   input  logic             exst_in,
   input  logic [CNT_W-1:0] rx_chunks_in,
   input  logic [CNT_W-1:0] tx_credits_in,
   input  logic             rxf_valid,
   input  logic [7:0]       rxf_data,
   input  logic             rxf_sof,
   input  logic             rxf_eof,
   output logic             rxf_pop,
   input  logic             spi_byte_req,
   input  logic             spi_hdr_seen,
   output logic [7:0]       spi_byte_out,
   output logic             irq_n
);
   import rce_pkg::*;

   localparam int CHUNK_LEN = PAYLOAD_BYTES + FTR_BYTES;
   localparam int IDX_W     = $clog2(CHUNK_LEN);
   localparam int PI_W      = $clog2(PAYLOAD_BYTES);

   generate
      if (PAYLOAD_BYTES < 8 || PAYLOAD_BYTES > 64 ||
          (PAYLOAD_BYTES & (PAYLOAD_BYTES - 1)) != 0) begin : g_bad_payload
         $error("PAYLOAD_BYTES must be a power of two from 8 to 64");
      end
      if (CNT_W < CNT_FLD_W) begin : g_bad_cnt
         $error("CNT_W must be at least the footer count width");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic             in_payload, last;
   logic [1:0]       fsel;
   logic [7:0]       pl_byte, ftr_byte;
   logic [31:0]      word;
   logic             dv_n, sv_n, ev_n;
   logic [SWO_W-1:0] swo_n;
   logic [EBO_W-1:0] ebo_n;

   assign in_payload = idx_q < IDX_W'(PAYLOAD_BYTES);
   assign last       = spi_byte_req && (idx_q == IDX_W'(PAYLOAD_BYTES - 1));
   assign fsel       = 2'(idx_q - IDX_W'(PAYLOAD_BYTES));

   always_comb begin
      case (fsel)
         2'd0:    ftr_byte = word[31:24];
         2'd1:    ftr_byte = word[23:16];
         2'd2:    ftr_byte = word[15:8];
         default: ftr_byte = word[7:0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q        <= '0;
         spi_byte_out <= 8'h00;
      end else if (spi_byte_req) begin
         idx_q        <= (idx_q == IDX_W'(CHUNK_LEN - 1)) ? '0 : idx_q + 1'b1;
         spi_byte_out <= in_payload ? pl_byte : ftr_byte;
      end
   end

   rce_payload #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_payload (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (spi_byte_req && in_payload),
      .last       (last),
      .pidx       (idx_q[PI_W-1:0]),
      .cfg_sync   (cfg_sync),
      .zero_align (zero_align),
      .rxf_valid  (rxf_valid),
      .rxf_data   (rxf_data),
      .rxf_sof    (rxf_sof),
      .rxf_eof    (rxf_eof),
      .pop        (rxf_pop),
      .pl_byte    (pl_byte),
      .dv_n       (dv_n),
      .sv_n       (sv_n),
      .swo_n      (swo_n),
      .ev_n       (ev_n),
      .ebo_n      (ebo_n)
   );

   rce_footer #(.CNT_W(CNT_W)) u_footer (
      .clk           (clk),
      .rst_n         (rst_n),
      .latch         (last),
      .cfg_sync      (cfg_sync),
      .exst_in       (exst_in),
      .rx_chunks_in  (rx_chunks_in),
      .tx_credits_in (tx_credits_in),
      .dv            (dv_n),
      .sv            (sv_n),
      .swo           (swo_n),
      .ev            (ev_n),
      .ebo           (ebo_n),
      .word          (word)
   );

   rce_irq #(.CNT_W(CNT_W)) u_irq (
      .clk           (clk),
      .rst_n         (rst_n),
      .latch         (last),
      .rx_chunks_in  (rx_chunks_in),
      .tx_credits_in (tx_credits_in),
      .exst_in       (exst_in),
      .spi_hdr_seen  (spi_hdr_seen),
      .irq_n         (irq_n)
   );

   AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_byte_req |=> $stable(idx_q));                            // R1
   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q < IDX_W'(CHUNK_LEN));                                   // R1

endmodule

// File: tb/tb_rce_engine.sv
module tb_rce_engine;
   localparam int P  = 16;
   localparam int CL = P + 4;
   localparam int NV = 7;

   // vector table: frame length, rx chunks, tx credits, exst, sync
   localparam int V_LEN [NV] = '{5, 16, 1, 0, 0, 12, 4};
   localparam int V_RCA [NV] = '{3, 40, 31, 0, 32, 255, 1};
   localparam int V_TXC [NV] = '{7, 31, 200, 0, 1, 32, 0};
   localparam int V_EX  [NV] = '{0, 1, 0, 1, 0, 1, 0};
   localparam int V_SY  [NV] = '{1, 1, 1, 1, 0, 1, 1};

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_sync = 1'b1, zero_align = 1'b0, exst_in = 1'b0;
   logic [7:0] rx_chunks_in = '0, tx_credits_in = '0;
   logic rxf_valid = 1'b0, rxf_sof = 1'b0, rxf_eof = 1'b0;
   logic [7:0] rxf_data = '0;
   logic rxf_pop, irq_n;
   logic spi_byte_req = 1'b0, spi_hdr_seen = 1'b0;
   logic [7:0] spi_byte_out;

   int total = 0, bad = 0;
   bit done = 0;
   bit [9:0] fq[$];
   logic pop_d = 1'b0;
   logic [7:0] rb [CL];
   logic [7:0] eb [P];

   always #4 clk = ~clk;

   rce_engine #(.PAYLOAD_BYTES(P), .CNT_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .zero_align(zero_align),
      .exst_in(exst_in), .rx_chunks_in(rx_chunks_in), .tx_credits_in(tx_credits_in),
      .rxf_valid(rxf_valid), .rxf_data(rxf_data), .rxf_sof(rxf_sof), .rxf_eof(rxf_eof),
      .rxf_pop(rxf_pop), .spi_byte_req(spi_byte_req), .spi_hdr_seen(spi_hdr_seen),
      .spi_byte_out(spi_byte_out), .irq_n(irq_n));

   always @(posedge clk) pop_d <= rxf_pop;

   always @(negedge clk) begin
      if (pop_d && fq.size() > 0) void'(fq.pop_front());
      rxf_valid = fq.size() > 0;
      if (fq.size() > 0) {rxf_sof, rxf_eof, rxf_data} = fq[0];
      else {rxf_sof, rxf_eof, rxf_data} = '0;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(int len, int base);
      for (int k = 0; k < len; k++)
         fq.push_back({k == 0, k == len - 1, 8'(base + k)});
   endtask

   task automatic clr_exp();
      for (int k = 0; k < P; k++) eb[k] = 8'h00;
   endtask

   task automatic put_exp(int pos, int base, int n);
      for (int k = 0; k < n; k++) eb[pos + k] = 8'(base + k);
   endtask

   task automatic read_chunk();
      @(negedge clk);
      spi_byte_req = 1'b1;
      for (int k = 0; k < CL; k++) begin
         @(negedge clk);
         rb[k] = spi_byte_out;
      end
      spi_byte_req = 1'b0;
   endtask

   function automatic logic [31:0] efoot(int ex, int sy, int rca, int txc, int dv,
                                         int sv, int swo, int ev, int ebo);
      logic [31:0] w;
      int r, t;
      r = (rca > 31) ? 31 : rca;
      t = (txc > 31) ? 31 : txc;
      w = '0;
      w[31] = ex[0]; w[29] = sy[0]; w[28:24] = 5'(r); w[21] = dv[0]; w[20] = sv[0];
      w[19:16] = 4'(swo); w[14] = ev[0]; w[13:8] = 6'(ebo); w[5:1] = 5'(t);
      w[0] = ~^w[31:1];
      return w;
   endfunction

   task automatic chk_chunk(string tag, logic [31:0] expf);
      logic [7:0] a, e;
      a = 8'h00; e = 8'h00;
      for (int k = P - 1; k >= 0; k--)
         if (rb[k] !== eb[k]) begin a = rb[k]; e = eb[k]; end
      chk({tag, " payload"}, {24'h0, a}, {24'h0, e});
      chk({tag, " footer"}, {rb[P], rb[P+1], rb[P+2], rb[P+3]}, expf);
   endtask

   task automatic hdr_pulse();
      @(negedge clk) spi_hdr_seen = 1'b1;
      @(negedge clk) spi_hdr_seen = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 irq_n in reset", {31'h0, irq_n}, 32'h1);
      chk("R12 byte_out in reset", {24'h0, spi_byte_out}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12 irq_n after reset, nothing available", {31'h0, irq_n}, 32'h1);

      // R10: interrupt on newly available credits, cleared by header
      tx_credits_in = 8'd5;
      @(negedge clk);
      chk("R10 credits appear -> irq", {31'h0, irq_n}, 32'h0);
      hdr_pulse();
      chk("R10 header clears irq", {31'h0, irq_n}, 32'h1);
      repeat (2) @(negedge clk);
      chk("R10 no re-raise without new event", {31'h0, irq_n}, 32'h1);
      exst_in = 1'b1;
      @(negedge clk);
      chk("R10 extended status -> irq", {31'h0, irq_n}, 32'h0);
      hdr_pulse();
      // R8 / R1: empty chunk carries exst and credits
      read_chunk();
      clr_exp();
      chk_chunk("R8 R1 R3 empty chunk", efoot(1, 1, 0, 5, 0, 0, 0, 0, 0));
      rx_chunks_in = 8'd2;
      @(negedge clk);
      chk("R10 rx chunks appear -> irq", {31'h0, irq_n}, 32'h0);
      hdr_pulse();

      // table of vectors: one frame per chunk, starting at byte 0
      for (int v = 0; v < NV; v++) begin
         rx_chunks_in  = 8'(V_RCA[v]);
         tx_credits_in = 8'(V_TXC[v]);
         exst_in       = V_EX[v][0];
         cfg_sync      = V_SY[v][0];
         push(V_LEN[v], 16 * v + 1);
         read_chunk();
         clr_exp();
         put_exp(0, 16 * v + 1, V_LEN[v]);
         if (V_LEN[v] > 0)
            chk_chunk($sformatf("R2 R9 R11 vector %0d", v),
                      efoot(V_EX[v], V_SY[v], V_RCA[v], V_TXC[v], 1, 1, 0, 1, V_LEN[v] - 1));
         else
            chk_chunk($sformatf("R3 R7 vector %0d", v),
                      efoot(V_EX[v], V_SY[v], V_RCA[v], V_TXC[v], 0, 0, 0, 0, 0));
      end
      rx_chunks_in = '0; tx_credits_in = '0; exst_in = 1'b0; cfg_sync = 1'b1;

      // R4 R5: frame spanning two chunks
      push(20, 8'h40);
      read_chunk(); clr_exp(); put_exp(0, 8'h40, 16);
      chk_chunk("R4 span first chunk", efoot(0, 1, 0, 0, 1, 1, 0, 0, 0));
      read_chunk(); clr_exp(); put_exp(0, 8'h50, 4);
      chk_chunk("R5 span second chunk", efoot(0, 1, 0, 0, 1, 0, 0, 1, 3));

      // R4 R5: misaligned start skipped, second end deferred
      push(19, 8'h60); push(4, 8'h90);
      read_chunk(); clr_exp(); put_exp(0, 8'h60, 16);
      chk_chunk("R4 long frame first chunk", efoot(0, 1, 0, 0, 1, 1, 0, 0, 0));
      read_chunk(); clr_exp(); put_exp(0, 8'h70, 3); put_exp(4, 8'h90, 3);
      chk_chunk("R4 R5 start at word 1, end deferred", efoot(0, 1, 0, 0, 1, 1, 1, 1, 2));
      read_chunk(); clr_exp(); put_exp(0, 8'h93, 1);
      chk_chunk("R5 deferred end served", efoot(0, 1, 0, 0, 1, 0, 0, 1, 0));

      // R6: zero-align mode
      zero_align = 1'b1;
      push(19, 8'h20); push(4, 8'hA0);
      read_chunk(); clr_exp(); put_exp(0, 8'h20, 16);
      chk_chunk("R6 first chunk", efoot(0, 1, 0, 0, 1, 1, 0, 0, 0));
      read_chunk(); clr_exp(); put_exp(0, 8'h30, 3);
      chk_chunk("R6 no start after end", efoot(0, 1, 0, 0, 1, 0, 0, 1, 2));
      read_chunk(); clr_exp(); put_exp(0, 8'hA0, 4);
      chk_chunk("R6 start at byte 0", efoot(0, 1, 0, 0, 1, 1, 0, 1, 3));
      zero_align = 1'b0;

      // R7: sync low leaves the queued frame untouched
      cfg_sync = 1'b0;
      push(3, 8'hC0);
      read_chunk(); clr_exp();
      chk_chunk("R7 sync low", efoot(0, 0, 0, 0, 0, 0, 0, 0, 0));
      cfg_sync = 1'b1;
      read_chunk(); clr_exp(); put_exp(0, 8'hC0, 3);
      chk_chunk("R7 frame kept for sync high", efoot(0, 1, 0, 0, 1, 1, 0, 1, 2));

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule